// File: doc/BRIEF.md
# Vector Register Store Address Generator

This block takes one 32-bit instruction word that stores a single vector/floating-point register to memory with an immediate offset. It decides whether the word belongs to this store class, and whether it is undefined or must fault. For a valid store it forms the effective address, the access width, the byte enables and the store data, and it states whether the base register is updated and with what value. Three addressing forms are handled by one decoder: scaled unsigned offset, pre-index and post-index.

The block exposes the base register number and the vector register number taken from the word. The surrounding pipeline returns the general-register value, the stack-pointer value and the 128-bit vector value in the same cycle as `in_valid`. One cycle later the block presents exactly one outcome: a memory write request, an undefined-encoding flag, a disabled-unit trap, a stack alignment fault, or a "not this instruction" flag. The block never talks to memory or to the register file itself.

Top module: `vstore_agu`

## Requirements
- R1: A word is accepted as this store only if bits 29:27 are 111, bit 26 is 1, bit 22 is 0, and either bits 25:24 are 01 (unsigned-offset form) or bits 25:24 are 00 with bit 21 at 0 and bits 11:10 at 01 or 11 (indexed form). Any other word raises `not_store` with no write and no writeback.
- R2: An accepted word with bit 23 at 1 and bits 31:30 not 00 raises `flt_undef` with no write and no writeback.
- R3: The scale is 4 when bit 23 is 1, and bits 31:30 otherwise. `mem_bytes` is 1 << scale. `mem_be` sets exactly bits [mem_bytes-1:0]. `mem_wdata` carries the low 8*mem_bytes bits of the vector value, and all bits above them are zero.
- R4: Post-index (bits 11:10 = 11 is pre, 01 is post): the write goes to the unmodified base, and the writeback value is base plus bits 20:12 sign-extended.
- R5: Pre-index: the write address and the writeback value are both base plus bits 20:12 sign-extended, unscaled.
- R6: Unsigned offset: the address is base plus bits 21:10 zero-extended and shifted left by the scale, and `wb_en` stays low.
- R7: The base register number is bits 9:5 and is shown on `base_idx`; the vector register number is bits 4:0 on `vec_idx`. Base number 31 selects `sp_value` and sets `wb_to_sp` with any writeback; other numbers select `gpr_value`.
- R8: With base number 31 and nonzero `sp_value[3:0]`, the block raises `flt_align` with no write and no writeback.
- R9: With `fp_enable` low, a defined store raises `flt_trap` with no write and no writeback. The priority is not_store, then undef, then trap, then alignment.
- R10: Each cycle with `in_valid` high produces `out_valid` on the next cycle with exactly one of `mem_req`, `flt_undef`, `flt_trap`, `flt_align`, `not_store` high. A cycle without `in_valid` leaves all of these low on the next cycle.
- R11: After reset, `out_valid`, `mem_req`, `wb_en` and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word present this cycle |
| instr | input | 32 | Instruction word |
| fp_enable | input | 1 | Vector/floating-point unit enabled |
| base_idx | output | 5 | Base register number for the register read |
| vec_idx | output | 5 | Vector register number for the register read |
| gpr_value | input | 64 | Value of general register `base_idx` |
| sp_value | input | 64 | Current stack pointer |
| vec_value | input | 128 | Value of vector register `vec_idx` |
| out_valid | output | 1 | Outcome present |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 64 | Write byte address |
| mem_bytes | output | 5 | Access width in bytes (1 to 16) |
| mem_be | output | 16 | Byte enables from lane 0 |
| mem_wdata | output | 128 | Write data, zero above the access width |
| wb_en | output | 1 | Base register update |
| wb_to_sp | output | 1 | Update targets the stack pointer |
| wb_idx | output | 5 | Register number to update |
| wb_value | output | 64 | New base value |
| flt_undef | output | 1 | Undefined encoding |
| flt_trap | output | 1 | Unit disabled trap |
| flt_align | output | 1 | Stack pointer misaligned |
| not_store | output | 1 | Word is not this store class |

## Verification
A decode fault in this block appears one cycle after the word as a wrong outcome flag or as a write that should have been blocked. A bad scale shows at once as a `mem_bytes`, `mem_be` and `mem_wdata` set that disagree with each other. An offset or ordering fault shows as a `mem_addr` or `wb_value` that is off by the immediate, or as the two being equal or unequal in the wrong form. No state persists across words, so every error is visible in the single outcome cycle of the word that caused it.

// File: rtl/vstore_agu.sv
module vstore_agu (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [31:0]  instr,
  input  logic         fp_enable,
  output logic [4:0]   base_idx,
  output logic [4:0]   vec_idx,
  input  logic [63:0]  gpr_value,
  input  logic [63:0]  sp_value,
  input  logic [127:0] vec_value,
  output logic         out_valid,
  output logic         mem_req,
  output logic [63:0]  mem_addr,
  output logic [4:0]   mem_bytes,
  output logic [15:0]  mem_be,
  output logic [127:0] mem_wdata,
  output logic         wb_en,
  output logic         wb_to_sp,
  output logic [4:0]   wb_idx,
  output logic [63:0]  wb_value,
  output logic         flt_undef,
  output logic         flt_trap,
  output logic         flt_align,
  output logic         not_store
);

  logic        fixed_ok, fam_uns, fam_idx, is_pre, match, bad_size;
  logic        use_sp, misal, go, do_wb;
  logic [2:0]  scale;
  logic [4:0]  nbytes;
  logic [63:0] base, off_idx, off_uns, sum, addr;
  logic [127:0] wmask;

  assign base_idx = instr[9:5];
  assign vec_idx  = instr[4:0];

  assign fixed_ok = (instr[29:27] == 3'b111) && instr[26];
  assign fam_uns  = (instr[25:24] == 2'b01);
  assign fam_idx  = (instr[25:24] == 2'b00) && !instr[21] && instr[10];
  assign is_pre   = fam_idx && instr[11];
  assign match    = fixed_ok && !instr[22] && (fam_uns || fam_idx);
  assign bad_size = instr[23] && (instr[31:30] != 2'b00);

  assign scale  = instr[23] ? 3'd4 : {1'b0, instr[31:30]};
  assign nbytes = 5'd1 << scale;

  assign use_sp = (instr[9:5] == 5'd31);
  assign base   = use_sp ? sp_value : gpr_value;
  assign misal  = use_sp && (sp_value[3:0] != 4'd0);

  assign off_idx = {{55{instr[20]}}, instr[20:12]};
  assign off_uns = {52'd0, instr[21:10]} << scale;
  assign sum     = base + (fam_uns ? off_uns : off_idx);
  assign addr    = (fam_idx && !is_pre) ? base : sum;

  assign wmask = ~({128{1'b1}} << {nbytes, 3'b000});

  assign go    = match && !bad_size && fp_enable && !misal;
  assign do_wb = go && !fam_uns;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      mem_bytes <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      wb_en     <= 1'b0;
      wb_to_sp  <= 1'b0;
      wb_idx    <= '0;
      wb_value  <= '0;
      flt_undef <= 1'b0;
      flt_trap  <= 1'b0;
      flt_align <= 1'b0;
      not_store <= 1'b0;
    end else begin
      out_valid <= in_valid;
      mem_req   <= in_valid && go;
      wb_en     <= in_valid && do_wb;
      wb_to_sp  <= in_valid && do_wb && use_sp;
      not_store <= in_valid && !match;
      flt_undef <= in_valid && match && bad_size;
      flt_trap  <= in_valid && match && !bad_size && !fp_enable;
      flt_align <= in_valid && match && !bad_size && fp_enable && misal;
      mem_addr  <= addr;
      mem_bytes <= nbytes;
      mem_be    <= ~(16'hFFFF << nbytes);
      mem_wdata <= vec_value & wmask;
      wb_idx    <= instr[9:5];
      wb_value  <= sum;
    end
  end

endmodule

module vstore_agu_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         out_valid,
  input logic         mem_req,
  input logic [4:0]   mem_bytes,
  input logic [15:0]  mem_be,
  input logic [127:0] mem_wdata,
  input logic         wb_en,
  input logic         wb_to_sp,
  input logic [4:0]   wb_idx,
  input logic         flt_undef,
  input logic         flt_trap,
  input logic         flt_align,
  input logic         not_store
);

  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !mem_req && !wb_en);

  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({mem_req, flt_undef, flt_trap, flt_align, not_store}) == 1);

  a_r3_be_count: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_be) == 32'(mem_bytes)) && mem_be[0]);

  a_r3_wdata_clear: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_wdata >> {mem_bytes, 3'b000}) == 128'd0);

  a_r9_wb_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> mem_req);

  a_r7_sp_target: assert property (@(posedge clk) disable iff (!rst_n)
    wb_to_sp |-> wb_en && (wb_idx == 5'd31));

  a_r8_align_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    flt_align |-> !mem_req && !wb_en);

endmodule

bind vstore_agu vstore_agu_chk u_chk (.*);

// File: tb/tb_vstore_agu.sv
module tb_vstore_agu;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [31:0]  instr = '0;
  logic         fp_enable = 1'b1;
  logic [4:0]   base_idx, vec_idx;
  logic [63:0]  gpr_value = '0;
  logic [63:0]  sp_value = '0;
  logic [127:0] vec_value = '0;
  logic         out_valid, mem_req, wb_en, wb_to_sp;
  logic [63:0]  mem_addr, wb_value;
  logic [4:0]   mem_bytes, wb_idx;
  logic [15:0]  mem_be;
  logic [127:0] mem_wdata;
  logic         flt_undef, flt_trap, flt_align, not_store;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  localparam logic [127:0] VEC = 128'h0123456789ABCDEF_FEDCBA9876543210;

  always #10 clk = ~clk;

  vstore_agu dut (.*);

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_idx(input logic [1:0] sz, input logic [1:0] opc,
                                          input logic [8:0] imm9, input bit pre,
                                          input logic [4:0] rn, input logic [4:0] rt);
    return {sz, 3'b111, 1'b1, 2'b00, opc, 1'b0, imm9, (pre ? 2'b11 : 2'b01), rn, rt};
  endfunction

  function automatic logic [31:0] enc_uns(input logic [1:0] sz, input logic [1:0] opc,
                                          input logic [11:0] imm12,
                                          input logic [4:0] rn, input logic [4:0] rt);
    return {sz, 3'b111, 1'b1, 2'b01, opc, imm12, rn, rt};
  endfunction

  function automatic logic [127:0] exp_data(input int n);
    logic [127:0] m;
    m = '0;
    for (int i = 0; i < n * 8; i++) m[i] = 1'b1;
    return VEC & m;
  endfunction

  function automatic logic [15:0] exp_be(input int n);
    logic [15:0] b;
    b = '0;
    for (int i = 0; i < n; i++) b[i] = 1'b1;
    return b;
  endfunction

  // drive at a falling edge, result sampled at the next falling edge
  task automatic issue(input logic [31:0] w, input logic [63:0] g, input logic [63:0] s, input logic en);
    instr = w; gpr_value = g; sp_value = s; fp_enable = en; vec_value = VEC; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_blocked(input string req, input logic u, input logic t, input logic a, input logic ns);
    chk(req, "out_valid", out_valid, 1);
    chk(req, "mem_req", mem_req, 0);
    chk(req, "wb_en", wb_en, 0);
    chk(req, "flt_undef", flt_undef, u);
    chk(req, "flt_trap", flt_trap, t);
    chk(req, "flt_align", flt_align, a);
    chk(req, "not_store", not_store, ns);
  endtask

  task automatic t_reset;
    chk("R11", "out_valid", out_valid, 0);
    chk("R11", "mem_req", mem_req, 0);
    chk("R11", "wb_en", wb_en, 0);
    chk("R11", "flags", {flt_undef, flt_trap, flt_align, not_store}, 0);
  endtask

  task automatic t_post64;
    logic [63:0] b = 64'h0000_0000_0000_1000;
    issue(enc_idx(2'b11, 2'b00, 9'h1F8, 0, 5'd3, 5'd7), b, 64'h0, 1'b1);
    chk("R4", "mem_req", mem_req, 1);
    chk("R4", "mem_addr", mem_addr, b);
    chk("R4", "wb_en", wb_en, 1);
    chk("R4", "wb_value", wb_value, b - 64'd8);
    chk("R4", "wb_idx", wb_idx, 5'd3);
    chk("R3", "bytes", mem_bytes, 5'd8);
    chk("R3", "be", mem_be, exp_be(8));
    chk("R3", "wdata", mem_wdata, exp_data(8));
  endtask

  task automatic t_pre8;
    logic [63:0] b = 64'h0000_00FF_FFFF_FF80;
    issue(enc_idx(2'b00, 2'b00, 9'h0FF, 1, 5'd12, 5'd1), b, 64'h0, 1'b1);
    chk("R5", "mem_addr", mem_addr, b + 64'd255);
    chk("R5", "wb_value", wb_value, b + 64'd255);
    chk("R5", "wb_en", wb_en, 1);
    chk("R3", "bytes", mem_bytes, 5'd1);
    chk("R3", "wdata", mem_wdata, exp_data(1));
  endtask

  task automatic t_uns128;
    logic [63:0] b = 64'h0000_0001_0000_0000;
    issue(enc_uns(2'b00, 2'b10, 12'hFFF, 5'd4, 5'd30), b, 64'h0, 1'b1);
    chk("R6", "mem_addr", mem_addr, b + 64'd65520);
    chk("R6", "wb_en", wb_en, 0);
    chk("R3", "bytes", mem_bytes, 5'd16);
    chk("R3", "be", mem_be, 16'hFFFF);
    chk("R3", "wdata", mem_wdata, VEC);
  endtask

  task automatic t_uns16;
    logic [63:0] b = 64'h40;
    issue(enc_uns(2'b01, 2'b00, 12'd3, 5'd0, 5'd2), b, 64'h0, 1'b1);
    chk("R6", "mem_addr", mem_addr, 64'h46);
    chk("R3", "be", mem_be, exp_be(2));
    chk("R3", "wdata", mem_wdata, exp_data(2));
  endtask

  task automatic t_undef;
    issue(enc_uns(2'b01, 2'b10, 12'd1, 5'd0, 5'd0), 64'h100, 64'h0, 1'b1);
    expect_blocked("R2", 1, 0, 0, 0);
    issue(enc_idx(2'b11, 2'b10, 9'd1, 1, 5'd31, 5'd0), 64'h0, 64'h8, 1'b0);
    expect_blocked("R2", 1, 0, 0, 0);
  endtask

  task automatic t_not_store;
    issue(enc_uns(2'b10, 2'b01, 12'd1, 5'd0, 5'd0), 64'h100, 64'h0, 1'b1);
    expect_blocked("R1", 0, 0, 0, 1);
    issue(enc_idx(2'b10, 2'b00, 9'd1, 0, 5'd0, 5'd0) | 32'h0020_0000, 64'h100, 64'h0, 1'b1);
    expect_blocked("R1", 0, 0, 0, 1);
    issue(enc_idx(2'b10, 2'b00, 9'd1, 0, 5'd0, 5'd0) & ~32'h0000_0C00, 64'h100, 64'h0, 1'b1);
    expect_blocked("R1", 0, 0, 0, 1);
    issue(enc_uns(2'b10, 2'b00, 12'd1, 5'd0, 5'd0) & ~32'h0400_0000, 64'h100, 64'h0, 1'b1);
    expect_blocked("R1", 0, 0, 0, 1);
  endtask

  task automatic t_sp;
    instr = enc_idx(2'b10, 2'b00, 9'h1F0, 1, 5'd31, 5'd9);
    #1;
    chk("R7", "base_idx", base_idx, 5'd31);
    chk("R7", "vec_idx", vec_idx, 5'd9);
    issue(enc_idx(2'b10, 2'b00, 9'h1F0, 1, 5'd31, 5'd9), 64'hDEAD_0000, 64'h2000, 1'b1);
    chk("R7", "mem_addr", mem_addr, 64'h1FF0);
    chk("R7", "wb_value", wb_value, 64'h1FF0);
    chk("R7", "wb_to_sp", wb_to_sp, 1);
    issue(enc_idx(2'b10, 2'b00, 9'h010, 1, 5'd5, 5'd9), 64'h3000, 64'h2000, 1'b1);
    chk("R7", "gpr base", mem_addr, 64'h3010);
    chk("R7", "wb_to_sp", wb_to_sp, 0);
  endtask

  task automatic t_align;
    issue(enc_idx(2'b11, 2'b00, 9'd8, 0, 5'd31, 5'd0), 64'h0, 64'h2004, 1'b1);
    expect_blocked("R8", 0, 0, 1, 0);
    issue(enc_idx(2'b11, 2'b00, 9'd8, 0, 5'd31, 5'd0), 64'h0, 64'h2004, 1'b0);
    expect_blocked("R9", 0, 1, 0, 0);
  endtask

  task automatic t_trap;
    issue(enc_uns(2'b10, 2'b00, 12'd1, 5'd2, 5'd0), 64'h100, 64'h0, 1'b0);
    expect_blocked("R9", 0, 1, 0, 0);
  endtask

  task automatic t_idle;
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10", "out_valid idle", out_valid, 0);
    chk("R10", "mem_req idle", mem_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_post64();
    t_pre8();
    t_uns128();
    t_uns16();
    t_undef();
    t_not_store();
    t_sp();
    t_align();
    t_trap();
    t_idle();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule